// File: doc/BRIEF.md
# UART Register Front End

This block is the software-visible register layer of a UART. It decodes 16-bit bus reads and writes into twelve word-spaced registers: the baud divisor halves, global, line and modem control, line and modem status, a scratch word, a pair of addresses that set and clear bits of one interrupt-enable word, the transmit holding register and the receive buffer. The serial shifter, baud generator and any FIFOs sit behind it and talk to it through plain strobes and level flags.

Every request is a single-cycle valid pulse. The response (acknowledge or error, with read data) is registered and appears one cycle later. Writing the transmit register hands the byte to the core with a one-cycle strobe, and raises a one-cycle transmit interrupt request when the transmit-empty enable is set. Reading the receive buffer pops a byte from the core. Error events from the core latch into sticky status bits that software clears by writing ones. The data-ready, holding-empty and transmitter-idle flags are never stored; they are sampled live into every line-status read.

Top module: `uart_csr_frontend`

## Requirements
- R1: Registers sit at byte offsets 0x00 divisor low, 0x04 divisor high, 0x08 global control, 0x0C line control, 0x10 modem control, 0x14 line status, 0x18 modem status, 0x1C scratch, 0x20 enable-set, 0x24 enable-clear, 0x28 transmit, 0x2C receive; the two divisor words, both control words, modem control and scratch store and return all 16 written bits.
- R2: After reset the divisor low word reads 0x0001, every other register reads 0x0000, and line status reads 0x0060 while the core reports holding-empty and idle with no received byte.
- R3: Any access whose size code is not 2'b01 (16-bit; 2'b00 is 8-bit, 2'b10 is 32-bit) gets an error response instead of an acknowledge, with read data 0x0000 and no change to any register; this check is made before the address check.
- R4: A correctly sized access to an offset with nonzero low two bits or at 0x30 and above gets an error response with read data 0x0000 and changes nothing.
- R5: A write to enable-set ORs the data into the enable word; a write to enable-clear clears each enable bit written as one; a read of either address returns the enable word.
- R6: Line-status bits 1 (overrun), 2 (parity), 3 (framing), 4 (break) and 7 (transmit done) are set by core events ev_line[0..4] respectively and cleared by writing one; a set event in the same cycle as the clearing write wins; writes to all other line-status bits are ignored.
- R7: A line-status read returns bit 0 from rx_ready, bit 5 from live_thr_empty and bit 6 from live_tx_idle as sampled in the request cycle, merged with the sticky bits.
- R8: Modem-status bit 0 is set by ev_cts and cleared by writing one to it; all other modem-status bits read zero and ignore writes.
- R9: A write to the transmit register puts its low byte on tx_byte with a one-cycle tx_strobe in the response cycle, and pulses tx_irq in the same cycle only if enable bit 1 was set; reading the transmit register returns the last byte written.
- R10: A read of the receive register returns rx_byte and pulses rx_pop in the response cycle when rx_ready is high; with rx_ready low it returns the last popped byte and does not pulse rx_pop; writes to it are acknowledged and have no effect.
- R11: Each request is answered exactly one cycle later by either rsp_ack or rsp_err, never both, and nothing is answered without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | Access size code, only 2'b01 accepted |
| req_addr | input | ADDR_W | Byte offset within the block |
| req_wdata | input | DATA_W | Write data |
| rsp_ack | output | 1 | Access accepted, one cycle after the request |
| rsp_err | output | 1 | Access rejected, one cycle after the request |
| rsp_rdata | output | DATA_W | Read data, zero unless a read is acknowledged |
| tx_byte | output | 8 | Byte last written to the transmit register |
| tx_strobe | output | 1 | New transmit byte pulse |
| tx_irq | output | 1 | Transmit interrupt request pulse |
| rx_byte | input | 8 | Next received byte from the core |
| rx_ready | input | 1 | Core holds a received byte |
| rx_pop | output | 1 | Received byte consumed pulse |
| live_thr_empty | input | 1 | Core transmit holding stage empty |
| live_tx_idle | input | 1 | Core transmitter fully idle |
| ev_line | input | 5 | Sticky event pulses: overrun, parity, framing, break, transmit done |
| ev_cts | input | 1 | Clear-to-send change event pulse |

## Verification
The embedded assertions check on every cycle that acknowledge and error never coincide, that an error carries zero data, that every response follows a request, that enable-set and enable-clear writes leave the expected bits in the enable word, that core events always land in the sticky bits, and that transmit strobes carry the written byte. Only the bench scenarios can show the address map, reset values, the live-flag merge in a status read, write-one-to-clear with a set event in the same cycle, ignored writes to status and receive registers, and the pop-versus-hold behaviour of the receive buffer.

// File: rtl/ucsr_pkg.sv
package ucsr_pkg;

  localparam int NUM_REGS = 12;

  typedef enum logic [3:0] {
    IDX_DLL    = 4'd0,
    IDX_DLH    = 4'd1,
    IDX_GCTL   = 4'd2,
    IDX_LCR    = 4'd3,
    IDX_MCR    = 4'd4,
    IDX_LSR    = 4'd5,
    IDX_MSR    = 4'd6,
    IDX_SCR    = 4'd7,
    IDX_IE_SET = 4'd8,
    IDX_IE_CLR = 4'd9,
    IDX_THR    = 4'd10,
    IDX_RBR    = 4'd11
  } ucsr_idx_e;

  localparam logic [1:0] SIZE_HALF = 2'b01;

  localparam int LSR_DR   = 0;
  localparam int LSR_THRE = 5;
  localparam int LSR_TEMT = 6;
  localparam logic [7:0] LSR_W1C_MASK = 8'h9E;
  localparam int MSR_SCTS = 0;
  localparam int IER_TXE  = 1;

  localparam int NUM_PLAIN = 6;

  // Event vector order: overrun, parity, framing, break, transmit done.
  function automatic logic [7:0] lsr_event_map(input logic [4:0] ev);
    return {ev[4], 2'b00, ev[3], ev[2], ev[1], ev[0], 1'b0};
  endfunction

  function automatic ucsr_idx_e plain_slot_idx(input int slot);
    case (slot)
      0:       return IDX_DLL;
      1:       return IDX_DLH;
      2:       return IDX_GCTL;
      3:       return IDX_LCR;
      4:       return IDX_MCR;
      default: return IDX_SCR;
    endcase
  endfunction

endpackage

// File: rtl/ucsr_decode.sv
module ucsr_decode
  import ucsr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output ucsr_idx_e         idx,
  output logic              size_bad,
  output logic              addr_bad
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              misaligned;
  logic              beyond;

  assign word       = addr[ADDR_W-1:2];
  assign misaligned = (addr[1:0] != 2'b00);
  assign beyond     = (word >= WORD_W'(NUM_REGS));

  // Size is judged first; address faults only matter for sized-right accesses.
  assign size_bad = (size != SIZE_HALF);
  assign addr_bad = !size_bad && (misaligned || beyond);
  assign idx      = (misaligned || beyond) ? IDX_DLL : ucsr_idx_e'(word[3:0]);

endmodule

// File: rtl/ucsr_regs.sv
module ucsr_regs
  import ucsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  ucsr_idx_e         idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [4:0]        ev_line,
  input  logic              ev_cts,
  input  logic              live_rx_ready,
  input  logic              live_thr_empty,
  input  logic              live_tx_idle,
  input  logic [7:0]        thr_value,
  input  logic [7:0]        rbr_value,
  output logic              ier_txe,
  output logic [DATA_W-1:0] rd_value
);
  localparam logic [DATA_W-1:0] DLL_RESET = DATA_W'(1);

  logic [DATA_W-1:0] plain_q [NUM_PLAIN];
  logic [DATA_W-1:0] ier_q;
  logic [7:0]        sticky_q;
  logic              scts_q;
  logic [7:0]        ev_bits;
  logic [7:0]        lsr_clear;
  logic [7:0]        lsr_view;

  // Plain storage: one register per slot, divisor low has its own reset value.
  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
    localparam ucsr_idx_e SLOT_IDX = plain_slot_idx(g);
    localparam logic [DATA_W-1:0] SLOT_RST = (g == 0) ? DLL_RESET : '0;
    always_ff @(posedge clk) begin
      if (rst) begin
        plain_q[g] <= SLOT_RST;
      end else if (wr_ok && idx == SLOT_IDX) begin
        plain_q[g] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q <= '0;
    end else if (wr_ok && idx == IDX_IE_SET) begin
      ier_q <= ier_q | wdata;
    end else if (wr_ok && idx == IDX_IE_CLR) begin
      ier_q <= ier_q & ~wdata;
    end
  end

  assign ev_bits   = lsr_event_map(ev_line);
  assign lsr_clear = (wr_ok && idx == IDX_LSR) ? (wdata[7:0] & LSR_W1C_MASK) : 8'h00;

  // Clearing first, then setting: an event in the clearing cycle survives.
  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= 8'h00;
      scts_q   <= 1'b0;
    end else begin
      sticky_q <= (sticky_q & ~lsr_clear) | ev_bits;
      scts_q   <= (scts_q & ~(wr_ok && idx == IDX_MSR && wdata[MSR_SCTS])) | ev_cts;
    end
  end

  always_comb begin
    lsr_view           = sticky_q & LSR_W1C_MASK;
    lsr_view[LSR_DR]   = live_rx_ready;
    lsr_view[LSR_THRE] = live_thr_empty;
    lsr_view[LSR_TEMT] = live_tx_idle;
  end

  assign ier_txe = ier_q[IER_TXE];

  always_comb begin
    case (idx)
      IDX_DLL:    rd_value = plain_q[0];
      IDX_DLH:    rd_value = plain_q[1];
      IDX_GCTL:   rd_value = plain_q[2];
      IDX_LCR:    rd_value = plain_q[3];
      IDX_MCR:    rd_value = plain_q[4];
      IDX_SCR:    rd_value = plain_q[5];
      IDX_LSR:    rd_value = DATA_W'(lsr_view);
      IDX_MSR:    rd_value = DATA_W'(scts_q);
      IDX_IE_SET,
      IDX_IE_CLR: rd_value = ier_q;
      IDX_THR:    rd_value = DATA_W'(thr_value);
      IDX_RBR:    rd_value = DATA_W'(rbr_value);
      default:    rd_value = '0;
    endcase
  end

  // R5: set address ORs in every written one
  p_ier_set_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && idx == IDX_IE_SET) |=> ((ier_q & $past(wdata)) == $past(wdata)));

  // R5: clear address leaves no written one standing
  p_ier_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && idx == IDX_IE_CLR) |=> ((ier_q & $past(wdata)) == '0));

  // R6: a core event always lands, even against a clearing write
  p_event_sticks_r6: assert property (@(posedge clk) disable iff (rst)
    (|ev_line) |=> ((sticky_q & $past(ev_bits)) == $past(ev_bits)));

  // R8: clear-to-send change always lands
  p_scts_sticks_r8: assert property (@(posedge clk) disable iff (rst)
    ev_cts |=> scts_q);

endmodule

// File: rtl/ucsr_core_port.sv
module ucsr_core_port
  import ucsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ok,
  input  logic       rd_ok,
  input  ucsr_idx_e  idx,
  input  logic [7:0] wbyte,
  input  logic       ier_txe,
  input  logic [7:0] rx_byte,
  input  logic       rx_ready,
  output logic [7:0] tx_byte,
  output logic       tx_strobe,
  output logic       tx_irq,
  output logic       rx_pop,
  output logic [7:0] thr_value,
  output logic [7:0] rbr_value
);
  logic [7:0] thr_q;
  logic [7:0] rbr_q;
  logic       thr_wr;
  logic       rbr_take;

  assign thr_wr   = wr_ok && idx == IDX_THR;
  assign rbr_take = rd_ok && idx == IDX_RBR && rx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q     <= 8'h00;
      rbr_q     <= 8'h00;
      tx_strobe <= 1'b0;
      tx_irq    <= 1'b0;
      rx_pop    <= 1'b0;
    end else begin
      tx_strobe <= thr_wr;
      tx_irq    <= thr_wr && ier_txe;
      rx_pop    <= rbr_take;
      if (thr_wr)   thr_q <= wbyte;
      if (rbr_take) rbr_q <= rx_byte;
    end
  end

  assign tx_byte   = thr_q;
  assign thr_value = thr_q;
  assign rbr_value = rx_ready ? rx_byte : rbr_q;

  // R9: interrupt request only rides along with a transmit strobe
  p_irq_with_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> tx_strobe);

  // R9: strobed byte is the one written in the request cycle
  p_tx_byte_r9: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> (tx_strobe && tx_byte == $past(wbyte)));

  // R10: a pop only follows a cycle in which the core had a byte
  p_pop_needs_data_r10: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(rx_ready));

endmodule

// File: rtl/uart_csr_frontend.sv
module uart_csr_frontend
  import ucsr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ack,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [7:0]        tx_byte,
  output logic              tx_strobe,
  output logic              tx_irq,
  input  logic [7:0]        rx_byte,
  input  logic              rx_ready,
  output logic              rx_pop,
  input  logic              live_thr_empty,
  input  logic              live_tx_idle,
  input  logic [4:0]        ev_line,
  input  logic              ev_cts
);
  ucsr_idx_e         idx;
  logic              size_bad;
  logic              addr_bad;
  logic              acc_ok;
  logic              wr_ok;
  logic              rd_ok;
  logic              ier_txe;
  logic [7:0]        thr_value;
  logic [7:0]        rbr_value;
  logic [DATA_W-1:0] rd_value;

  ucsr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .size     (req_size),
    .addr     (req_addr),
    .idx      (idx),
    .size_bad (size_bad),
    .addr_bad (addr_bad)
  );

  assign acc_ok = req_valid && !size_bad && !addr_bad;
  assign wr_ok  = acc_ok && req_write;
  assign rd_ok  = acc_ok && !req_write;

  ucsr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk            (clk),
    .rst            (rst),
    .wr_ok          (wr_ok),
    .idx            (idx),
    .wdata          (req_wdata),
    .ev_line        (ev_line),
    .ev_cts         (ev_cts),
    .live_rx_ready  (rx_ready),
    .live_thr_empty (live_thr_empty),
    .live_tx_idle   (live_tx_idle),
    .thr_value      (thr_value),
    .rbr_value      (rbr_value),
    .ier_txe        (ier_txe),
    .rd_value       (rd_value)
  );

  ucsr_core_port u_core (
    .clk       (clk),
    .rst       (rst),
    .wr_ok     (wr_ok),
    .rd_ok     (rd_ok),
    .idx       (idx),
    .wbyte     (req_wdata[7:0]),
    .ier_txe   (ier_txe),
    .rx_byte   (rx_byte),
    .rx_ready  (rx_ready),
    .tx_byte   (tx_byte),
    .tx_strobe (tx_strobe),
    .tx_irq    (tx_irq),
    .rx_pop    (rx_pop),
    .thr_value (thr_value),
    .rbr_value (rbr_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ack   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ack   <= acc_ok;
      rsp_err   <= req_valid && (size_bad || addr_bad);
      rsp_rdata <= rd_ok ? rd_value : '0;
    end
  end

  // R11: one response kind at a time
  p_ack_err_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(rsp_ack && rsp_err));

  // R11: no response without a request one cycle earlier
  p_resp_follows_req_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_ack || rsp_err) |-> $past(req_valid));

  // R3: rejected accesses return zero data
  p_err_zero_data_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0));

  // R3: a wrongly sized request is always rejected
  p_size_rejected_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size != SIZE_HALF) |=> rsp_err);

endmodule

// File: tb/uart_csr_frontend_test.sv
module uart_csr_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_write;
  logic [1:0]  req_size;
  logic [5:0]  req_addr;
  logic [15:0] req_wdata;
  logic        rsp_ack;
  logic        rsp_err;
  logic [15:0] rsp_rdata;
  logic [7:0]  tx_byte;
  logic        tx_strobe;
  logic        tx_irq;
  logic [7:0]  rx_byte;
  logic        rx_ready;
  logic        rx_pop;
  logic        live_thr_empty;
  logic        live_tx_idle;
  logic [4:0]  ev_line;
  logic        ev_cts;

  int checks = 0;
  int errors = 0;

  // Captured response of the last access
  logic        c_ack, c_err, c_txs, c_irq, c_pop;
  logic [15:0] c_data;
  logic [7:0]  c_txb;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_csr_frontend uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .tx_byte(tx_byte), .tx_strobe(tx_strobe), .tx_irq(tx_irq),
    .rx_byte(rx_byte), .rx_ready(rx_ready), .rx_pop(rx_pop),
    .live_thr_empty(live_thr_empty), .live_tx_idle(live_tx_idle),
    .ev_line(ev_line), .ev_cts(ev_cts)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
    end
  endtask

  task automatic capture();
    c_ack = rsp_ack; c_err = rsp_err; c_data = rsp_rdata;
    c_txs = tx_strobe; c_irq = tx_irq; c_pop = rx_pop; c_txb = tx_byte;
  endtask

  task automatic access(input logic w, input logic [1:0] sz,
                        input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = 16'h0000;
    capture();
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    access(1'b1, 2'b01, a, d);
  endtask

  task automatic rd_expect(input string req, input logic [5:0] a, input logic [15:0] exp);
    access(1'b0, 2'b01, a, 16'h0000);
    check(req, $sformatf("ack @0x%02h", a), 16'(c_ack), 16'h1);
    check(req, $sformatf("read @0x%02h", a), c_data, exp);
  endtask

  task automatic t_reset();
    check("R2", "idle ack", 16'(rsp_ack), 16'h0);
    check("R2", "idle err", 16'(rsp_err), 16'h0);
    rd_expect("R2", 6'h00, 16'h0001);
    for (int a = 4; a <= 16; a += 4) rd_expect("R2", 6'(a), 16'h0000);
    rd_expect("R2", 6'h14, 16'h0060);
    for (int a = 24; a <= 44; a += 4) rd_expect("R2", 6'(a), 16'h0000);
  endtask

  task automatic t_plain();
    wr(6'h00, 16'h0100);
    wr(6'h04, 16'hA5C3);
    wr(6'h08, 16'h1234);
    wr(6'h0C, 16'h00FF);
    wr(6'h10, 16'h8001);
    wr(6'h1C, 16'hBEEF);
    rd_expect("R1", 6'h00, 16'h0100);
    rd_expect("R1", 6'h04, 16'hA5C3);
    rd_expect("R1", 6'h08, 16'h1234);
    rd_expect("R1", 6'h0C, 16'h00FF);
    rd_expect("R1", 6'h10, 16'h8001);
    rd_expect("R1", 6'h1C, 16'hBEEF);
  endtask

  task automatic t_size();
    access(1'b1, 2'b10, 6'h00, 16'h5555);
    check("R3", "32-bit write err", 16'(c_err), 16'h1);
    check("R3", "32-bit write ack", 16'(c_ack), 16'h0);
    access(1'b0, 2'b00, 6'h04, 16'h0000);
    check("R3", "8-bit read err", 16'(c_err), 16'h1);
    check("R3", "8-bit read data", c_data, 16'h0000);
    access(1'b1, 2'b00, 6'h31, 16'hFFFF);
    check("R3", "bad size at bad offset err", 16'(c_err), 16'h1);
    rd_expect("R3", 6'h00, 16'h0100);
  endtask

  task automatic t_addr();
    access(1'b0, 2'b01, 6'h30, 16'h0000);
    check("R4", "offset 0x30 err", 16'(c_err), 16'h1);
    check("R4", "offset 0x30 data", c_data, 16'h0000);
    access(1'b1, 2'b01, 6'h06, 16'h7777);
    check("R4", "misaligned err", 16'(c_err), 16'h1);
    check("R4", "misaligned ack", 16'(c_ack), 16'h0);
    access(1'b0, 2'b01, 6'h3C, 16'h0000);
    check("R4", "offset 0x3C err", 16'(c_err), 16'h1);
    rd_expect("R4", 6'h04, 16'hA5C3);
  endtask

  task automatic t_ier();
    wr(6'h20, 16'h0003);
    rd_expect("R5", 6'h24, 16'h0003);
    wr(6'h20, 16'h0010);
    rd_expect("R5", 6'h20, 16'h0013);
    wr(6'h24, 16'h0001);
    rd_expect("R5", 6'h20, 16'h0012);
  endtask

  task automatic t_thr();
    wr(6'h28, 16'hFF41);
    check("R9", "strobe", 16'(c_txs), 16'h1);
    check("R9", "byte", 16'(c_txb), 16'h0041);
    check("R9", "irq with enable", 16'(c_irq), 16'h1);
    wr(6'h24, 16'h0002);
    check("R9", "strobe after other write", 16'(c_txs), 16'h0);
    wr(6'h28, 16'h005A);
    check("R9", "strobe no enable", 16'(c_txs), 16'h1);
    check("R9", "irq without enable", 16'(c_irq), 16'h0);
    rd_expect("R9", 6'h28, 16'h005A);
    check("R9", "strobe after read", 16'(c_txs), 16'h0);
  endtask

  task automatic t_lsr();
    @(negedge clk); ev_line = 5'b11111;
    @(negedge clk); ev_line = 5'b00000;
    rd_expect("R6", 6'h14, 16'h00FE);
    wr(6'h14, 16'h0006);
    rd_expect("R6", 6'h14, 16'h00F8);
    wr(6'h14, 16'h0061);
    rd_expect("R6", 6'h14, 16'h00F8);
    wr(6'h14, 16'hFFFF);
    rd_expect("R6", 6'h14, 16'h0060);
    // set event in the same cycle as the clearing write
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'b01; req_addr = 6'h14;
    req_wdata = 16'h0002; ev_line = 5'b00001;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; ev_line = 5'b00000;
    rd_expect("R6", 6'h14, 16'h0062);
  endtask

  task automatic t_live();
    rx_ready = 1'b1; rx_byte = 8'h3C; live_thr_empty = 1'b0; live_tx_idle = 1'b0;
    rd_expect("R7", 6'h14, 16'h0003);
    check("R7", "no pop on status read", 16'(c_pop), 16'h0);
    rx_ready = 1'b0; live_thr_empty = 1'b1; live_tx_idle = 1'b0;
    rd_expect("R7", 6'h14, 16'h0022);
    live_tx_idle = 1'b1;
    wr(6'h14, 16'h0002);
    rd_expect("R7", 6'h14, 16'h0060);
  endtask

  task automatic t_msr();
    @(negedge clk); ev_cts = 1'b1;
    @(negedge clk); ev_cts = 1'b0;
    rd_expect("R8", 6'h18, 16'h0001);
    wr(6'h18, 16'hFFFE);
    rd_expect("R8", 6'h18, 16'h0001);
    wr(6'h18, 16'h0001);
    rd_expect("R8", 6'h18, 16'h0000);
  endtask

  task automatic t_rbr();
    rx_ready = 1'b1; rx_byte = 8'h3C;
    rd_expect("R10", 6'h2C, 16'h003C);
    check("R10", "pop with data", 16'(c_pop), 16'h1);
    rx_ready = 1'b0; rx_byte = 8'h77;
    rd_expect("R10", 6'h2C, 16'h003C);
    check("R10", "no pop when empty", 16'(c_pop), 16'h0);
    wr(6'h2C, 16'h00AA);
    check("R10", "write acked", 16'(c_ack), 16'h1);
    check("R10", "write no pop", 16'(c_pop), 16'h0);
    rd_expect("R10", 6'h2C, 16'h003C);
  endtask

  task automatic t_handshake();
    access(1'b0, 2'b01, 6'h08, 16'h0000);
    check("R11", "ack one cycle later", 16'(c_ack), 16'h1);
    @(negedge clk);
    check("R11", "ack drops without request", 16'(rsp_ack), 16'h0);
    check("R11", "no err without request", 16'(rsp_err), 16'h0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_size = 2'b01;
    req_addr = '0; req_wdata = '0; rx_byte = 8'h00; rx_ready = 1'b0;
    live_thr_empty = 1'b1; live_tx_idle = 1'b1; ev_line = 5'b00000; ev_cts = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_size();
    t_addr();
    t_ier();
    t_thr();
    t_lsr();
    t_live();
    t_msr();
    t_rbr();
    t_handshake();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule